// File: doc/BRIEF.md
# Address Translation Unit with Hardware Page-Table Walk

This block converts every 32-bit virtual address, whether it comes from instruction fetch or from a load or store, into a physical address before memory is touched. The upper 16 bits of the virtual address select a page. The lower 16 bits pass through unchanged as the offset. A small fully associative translation cache holds recent page-to-frame mappings. A request that matches one of them is answered combinationally in the same cycle.

When a request misses the cache, a hardware walker takes over. It reads one page-table entry over a ready/valid memory read port and installs the mapping if the entry is present. It then answers with the translated address. If the entry is absent, the walker reports a page fault instead, carrying the faulting virtual address and the access kind for the exception handler. After the handler repairs the table, the retried access walks again and completes. An invalidate-all input lets software discard cached mappings after it edits the table.

Top module: `tlbw_top`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `rd_valid` are all low.
- R2: A completed translation drives `paddr` = {frame, `req_vaddr[15:0]`}. The frame is 16 bits wide and comes from the page-table entry or from the cached mapping.
- R3: A request that matches a cached mapping raises `done` in the same cycle as `req_valid`, with `busy` low, and issues no memory read.
- R4: A miss raises `busy` from the next cycle until the answer cycle. It issues one read at `pt_base + 4*vpn`, where vpn = `req_vaddr[31:16]`, and holds `rd_valid` and `rd_addr` steady until `rd_ready`.
- R5: A present entry found by a walk is installed, so a later access to the same page hits with no read.
- R6: An entry with bit 31 clear ends the walk with `fault` high for one cycle and `done` low. In that cycle `fault_vaddr` equals the request's full virtual address and `fault_kind` equals its access kind (0 fetch, 1 load, 2 store). Nothing is installed, so a retry walks again.
- R7: Once the entry's bit 31 is set in memory, a retried access walks, completes with the correct address, and then hits.
- R8: Refills go to the cache slots in round-robin order. With 8 slots, the ninth distinct refill evicts the first mapping installed and keeps the other eight.
- R9: Asserting `inval_all` clears every cached mapping. A request in the same cycle as `inval_all` is treated as a miss.
- R10: Entry bits 30:16 are ignored. Only bit 31 (present) and bits 15:0 (frame) affect the result.
- R11: `req_valid` is ignored while `busy` is high. The pending walk's address and result are not disturbed, and no extra read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| pt_base | input | 32 | Byte address of the page table |
| inval_all | input | 1 | Discard all cached mappings |
| busy | output | 1 | Walk in progress, requests ignored |
| done | output | 1 | Translation complete, `paddr` valid |
| paddr | output | 32 | Physical address |
| fault | output | 1 | Page fault, one-cycle pulse |
| fault_vaddr | output | 32 | Virtual address that faulted |
| fault_kind | output | 2 | Access kind of the faulting request |
| rd_valid | output | 1 | Page-table read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 32 | Byte address of the entry to read |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Page-table entry word |

## Verification
The assertions check the local rules on every cycle:
- the read request holds until it is accepted;
- reads occur only during a walk;
- `done` and `fault` are mutually exclusive;
- a fault reports the address captured when the missing request was accepted;
- a hit answer preserves the offset and issues no read.

Other behaviour depends on history across many requests, so only the bench scenarios can show it:
- which mapping round-robin replacement evicts;
- that installs persist;
- that invalidate-all clears the cache;
- that a repaired entry is found on retry;
- that ignored requests leave the pending walk untouched.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 16;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PFN_W    = 16;
    localparam int PRESENT_BIT = 31;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_ISSUE,
        WK_WAIT,
        WK_ANSWER
    } walk_state_e;

    typedef struct packed {
        logic             live;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } xlat_slot_t;

    function automatic logic entry_present(input logic [31:0] word);
        return word[PRESENT_BIT];
    endfunction

    function automatic logic [PFN_W-1:0] entry_frame(input logic [31:0] word);
        return word[PFN_W-1:0];
    endfunction

    function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                   input logic [VPN_W-1:0] vpn);
        return base + (VA_W'(vpn) << 2);
    endfunction

endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam
    import tlbw_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic [PFN_W-1:0] look_pfn,
    input  logic             clear_all,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    xlat_slot_t             slot_q [SLOTS];
    logic [PTR_W-1:0]       victim_q;
    logic [SLOTS-1:0]       match;
    logic [PFN_W-1:0]       pfn_or [SLOTS+1];

    assign pfn_or[0] = '0;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign match[i]    = slot_q[i].live && (slot_q[i].vpn == look_vpn);
        assign pfn_or[i+1] = pfn_or[i] | (match[i] ? slot_q[i].pfn : '0);

        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                slot_q[i].live <= 1'b0;
            end else if (fill_en && (victim_q == PTR_W'(i))) begin
                slot_q[i].live <= 1'b1;
            end
            if (fill_en && (victim_q == PTR_W'(i))) begin
                slot_q[i].vpn <= fill_vpn;
                slot_q[i].pfn <= fill_pfn;
            end
        end
    end

    assign look_hit = |match;
    assign look_pfn = pfn_or[SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_q <= '0;
        end else if (fill_en && !clear_all) begin
            victim_q <= (victim_q == PTR_W'(SLOTS - 1)) ? '0 : victim_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlbw_walker.sv
module tlbw_walker
    import tlbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VA_W-1:0]  start_vaddr,
    input  logic [1:0]       start_kind,
    input  logic [VA_W-1:0]  start_base,
    output logic             busy,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [VA_W-1:0]  rd_addr,
    input  logic             rd_rvalid,
    input  logic [31:0]      rd_rdata,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             ans_done,
    output logic             ans_fault,
    output logic [VA_W-1:0]  ans_paddr,
    output logic [VA_W-1:0]  held_vaddr,
    output logic [1:0]       held_kind
);
    walk_state_e      state_q;
    logic [VA_W-1:0]  vaddr_q;
    logic [VA_W-1:0]  base_q;
    logic [1:0]       kind_q;
    logic [PFN_W-1:0] pfn_q;
    logic             miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_IDLE;
            vaddr_q <= '0;
            base_q  <= '0;
            kind_q  <= '0;
            pfn_q   <= '0;
            miss_q  <= 1'b0;
        end else begin
            unique case (state_q)
                WK_IDLE: if (start) begin
                    state_q <= WK_ISSUE;
                    vaddr_q <= start_vaddr;
                    base_q  <= start_base;
                    kind_q  <= start_kind;
                end
                WK_ISSUE: if (rd_ready) state_q <= WK_WAIT;
                WK_WAIT: if (rd_rvalid) begin
                    state_q <= WK_ANSWER;
                    pfn_q   <= entry_frame(rd_rdata);
                    miss_q  <= !entry_present(rd_rdata);
                end
                WK_ANSWER: state_q <= WK_IDLE;
                default:   state_q <= WK_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != WK_IDLE);
    assign rd_valid   = (state_q == WK_ISSUE);
    assign rd_addr    = entry_addr(base_q, vaddr_q[VA_W-1 -: VPN_W]);
    assign fill_en    = (state_q == WK_WAIT) && rd_rvalid && entry_present(rd_rdata);
    assign fill_vpn   = vaddr_q[VA_W-1 -: VPN_W];
    assign fill_pfn   = entry_frame(rd_rdata);
    assign ans_done   = (state_q == WK_ANSWER) && !miss_q;
    assign ans_fault  = (state_q == WK_ANSWER) && miss_q;
    assign ans_paddr  = {pfn_q, vaddr_q[OFF_W-1:0]};
    assign held_vaddr = vaddr_q;
    assign held_kind  = kind_q;

endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
    import tlbw_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic [31:0] pt_base,
    input  logic        inval_all,
    output logic        busy,
    output logic        done,
    output logic [31:0] paddr,
    output logic        fault,
    output logic [31:0] fault_vaddr,
    output logic [1:0]  fault_kind,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [31:0] rd_addr,
    input  logic        rd_rvalid,
    input  logic [31:0] rd_rdata
);
    logic             cam_hit;
    logic [PFN_W-1:0] cam_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic             fast_ok;
    logic             walk_go;
    logic             ans_done;
    logic [VA_W-1:0]  ans_paddr;

    tlbw_cam #(.SLOTS(SLOTS)) cam_i (
        .clk       (clk),
        .rst       (rst),
        .look_vpn  (req_vaddr[VA_W-1 -: VPN_W]),
        .look_hit  (cam_hit),
        .look_pfn  (cam_pfn),
        .clear_all (inval_all),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_pfn  (fill_pfn)
    );

    assign fast_ok = req_valid && !busy && cam_hit && !inval_all;
    assign walk_go = req_valid && !busy && !(cam_hit && !inval_all);

    tlbw_walker walk_i (
        .clk         (clk),
        .rst         (rst),
        .start       (walk_go),
        .start_vaddr (req_vaddr),
        .start_kind  (req_kind),
        .start_base  (pt_base),
        .busy        (busy),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_addr     (rd_addr),
        .rd_rvalid   (rd_rvalid),
        .rd_rdata    (rd_rdata),
        .fill_en     (fill_en),
        .fill_vpn    (fill_vpn),
        .fill_pfn    (fill_pfn),
        .ans_done    (ans_done),
        .ans_fault   (fault),
        .ans_paddr   (ans_paddr),
        .held_vaddr  (fault_vaddr),
        .held_kind   (fault_kind)
    );

    assign done  = fast_ok || ans_done;
    assign paddr = ans_done ? ans_paddr : {cam_pfn, req_vaddr[OFF_W-1:0]};

endmodule

// File: rtl/tlbw_chk.sv
module tlbw_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        busy,
    input logic        done,
    input logic [31:0] paddr,
    input logic        fault,
    input logic [31:0] fault_vaddr,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [31:0] rd_addr
);
    logic [31:0] taken_va;

    always_ff @(posedge clk) begin
        if (rst) taken_va <= '0;
        else if (req_valid && !busy && !done) taken_va <= req_vaddr;
    end

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R4

    AST_READ_ONLY_WALKING: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy); // R4

    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fault)); // R6

    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
        fault |-> fault_vaddr == taken_va); // R6

    AST_FAST_OFFSET: assert property (@(posedge clk) disable iff (rst)
        done && !busy |-> paddr[15:0] == req_vaddr[15:0] && !rd_valid); // R3

    AST_NO_ANSWER_IDLE_NOREQ: assert property (@(posedge clk) disable iff (rst)
        !busy && !req_valid |-> !done && !fault); // R11

endmodule

bind tlbw_top tlbw_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .busy        (busy),
    .done        (done),
    .paddr       (paddr),
    .fault       (fault),
    .fault_vaddr (fault_vaddr),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr)
);

// File: tb/tlbw_top_tb_top.sv
module tlbw_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] pt_base = 32'h0004_0000;
    logic        inval_all = 1'b0;
    logic        busy, done, fault, rd_valid;
    logic [31:0] paddr, fault_vaddr, rd_addr;
    logic [1:0]  fault_kind;
    logic        rd_ready = 1'b0;
    logic        rd_rvalid = 1'b0;
    logic [31:0] rd_rdata = '0;

    int checks = 0;
    int failures = 0;
    int walks = 0;
    int cyc = 0;
    logic [15:0] exp_vpn = '0;
    logic        bad_page [256];
    bit          pend = 1'b0;
    int          pend_lat = 0;
    logic [15:0] pend_vpn = '0;

    always #2 clk = ~clk;

    tlbw_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .pt_base(pt_base), .inval_all(inval_all),
        .busy(busy), .done(done), .paddr(paddr), .fault(fault),
        .fault_vaddr(fault_vaddr), .fault_kind(fault_kind),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata)
    );

    function automatic logic [15:0] frame_of(input logic [15:0] vpn);
        return vpn * 16'd37 + 16'h0103;
    endfunction

    // R10: junk in bits 30:16 that must not reach the result
    function automatic logic [31:0] entry_word(input logic [15:0] vpn);
        return {~bad_page[vpn[7:0]], vpn[6:0], 8'hA5, frame_of(vpn)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // page-table memory model, driven away from the active edge
    always @(negedge clk) begin
        rd_ready  = (cyc % 3) != 1;
        rd_rvalid = 1'b0;
        if (pend) begin
            if (pend_lat == 0) begin
                rd_rvalid = 1'b1;
                rd_rdata  = entry_word(pend_vpn);
                pend      = 1'b0;
            end else begin
                pend_lat--;
            end
        end
        if (rd_valid && rd_ready) begin
            check(rd_addr == pt_base + {14'd0, exp_vpn, 2'b00}, "R4", "entry address",
                  rd_addr, pt_base + {14'd0, exp_vpn, 2'b00});
            pend     = 1'b1;
            pend_vpn = rd_addr[17:2] - pt_base[17:2];
            pend_lat = walks % 3;
            walks++;
        end
    end

    task automatic xlate(input logic [31:0] va, input logic [1:0] kind,
                         input bit exp_hit, input bit junk, input string req);
        int w0;
        bit got;
        bit exp_flt;
        logic [31:0] exp_pa;
        w0      = walks;
        exp_flt = bad_page[va[23:16]];
        exp_pa  = {frame_of(va[31:16]), va[15:0]};
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; exp_vpn = va[31:16];
        #1;
        if (exp_hit) begin
            check(done && !busy && !fault, req, "same-cycle hit", {31'd0, done}, 32'd1);
            check(paddr == exp_pa, req, "hit paddr (R2)", paddr, exp_pa);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check(walks == w0, req, "hit issued no read (R3)", walks, w0);
        end else begin
            check(!done && !fault, req, "miss not answered at once", {31'd0, done}, 32'd0);
            got = 1'b0;
            for (int n = 0; n < 100 && !got; n++) begin
                @(negedge clk);
                if (junk) begin
                    req_valid = 1'b1; req_vaddr = va ^ 32'h0F0F_0000; req_kind = 2'd2;
                end else begin
                    req_valid = 1'b0;
                end
                #1;
                if (done || fault) got = 1'b1;
                else check(busy, "R4", "busy during walk", {31'd0, busy}, 32'd1);
            end
            req_valid = 1'b0;
            check(got, req, "walk answered", {31'd0, got}, 32'd1);
            check(fault == exp_flt, req, "fault flag (R6)", {31'd0, fault}, {31'd0, exp_flt});
            if (exp_flt) begin
                check(fault_vaddr == va, "R6", "fault vaddr", fault_vaddr, va);
                check(fault_kind == kind, "R6", "fault kind", {30'd0, fault_kind}, {30'd0, kind});
            end else begin
                check(paddr == exp_pa, req, "walk paddr (R2 R10)", paddr, exp_pa);
            end
            check(walks == w0 + 1, req, "exactly one read (R11)", walks, w0 + 1);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bad_page[i] = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !fault && !rd_valid, "R1", "reset outputs",
              {28'd0, busy, done, fault, rd_valid}, 32'd0);
        rst = 1'b0;

        // R5 R4: fill eight pages, every third walk sees junk requests (R11)
        for (int p = 0; p < 8; p++)
            xlate({16'h0010 + 16'(p), 16'(p * 4099)}, 2'(p % 3), 1'b0, (p % 3) == 0, "R5");
        // R3 R2: offset sweep over every cached page
        for (int p = 0; p < 8; p++) begin
            xlate({16'h0010 + 16'(p), 16'h0000}, 2'd0, 1'b1, 1'b0, "R3");
            xlate({16'h0010 + 16'(p), 16'hFFFF}, 2'd1, 1'b1, 1'b0, "R2");
            xlate({16'h0010 + 16'(p), 16'(p * 13 + 1)}, 2'd2, 1'b1, 1'b0, "R3");
        end
        // R8: ninth refill evicts the first installed page
        xlate(32'h0018_0042, 2'd1, 1'b0, 1'b0, "R8");
        for (int p = 1; p < 9; p++)
            xlate({16'h0010 + 16'(p), 16'h0123}, 2'd0, 1'b1, 1'b0, "R8");
        xlate(32'h0010_0123, 2'd0, 1'b0, 1'b0, "R8");

        // R6: absent entry faults, retry walks again
        bad_page[8'h53] = 1'b1;
        xlate(32'h0053_1020, 2'd1, 1'b0, 1'b0, "R6");
        xlate(32'h0053_1020, 2'd1, 1'b0, 1'b1, "R6");
        // R7: after repair the retry completes and then hits
        bad_page[8'h53] = 1'b0;
        xlate(32'h0053_1020, 2'd1, 1'b0, 1'b0, "R7");
        xlate(32'h0053_1020, 2'd2, 1'b1, 1'b0, "R7");

        // R9: invalidate-all, then a new table base
        @(negedge clk); inval_all = 1'b1;
        @(negedge clk); inval_all = 1'b0;
        xlate(32'h0053_0004, 2'd0, 1'b0, 1'b0, "R9");
        pt_base = 32'h0010_0000;
        xlate(32'h0012_7777, 2'd1, 1'b0, 1'b0, "R9");
        xlate(32'h0012_7778, 2'd1, 1'b1, 1'b0, "R9");
        // R9: request in the same cycle as invalidate is a miss
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0012_0001; inval_all = 1'b1; #1;
        check(!done, "R9", "same-cycle invalidate blocks hit", {31'd0, done}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0; inval_all = 1'b0;
        for (int n = 0; n < 100 && !done; n++) @(negedge clk);
        #1;
        check(done && paddr == {frame_of(16'h0012), 16'h0001}, "R9", "walk after invalidate",
              paddr, {frame_of(16'h0012), 16'h0001});
        // R10: frame unaffected by junk bits in a large page number
        xlate(32'h00FE_ABCD, 2'd0, 1'b0, 1'b1, "R10");
        xlate(32'h00FE_0000, 2'd1, 1'b1, 1'b0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule